// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block holds a 128-bit protection register made of eight 16-bit words, plus a lock word that controls it. Four words carry a factory identifier that comes from a parameter and can never be changed. Four further words form a user segment that is one-time-programmable: a program operation can only clear bits from 1 to 0. The lock word has two user bits. Clearing the first one freezes the user segment and the lock word. Clearing the second one permanently raises a protect signal for the security block, which is parameter block 0.

A program request carries a word address and 16 bits of data. The block accepts it when it is idle, stays busy for a fixed number of cycles, and then commits the result. At completion it pulses a done flag together with an error flag. A read port returns the addressed word combinationally.

Storage is made of ordinary flops. Only the factory-init input sets these flops to their erased state; the main reset does not touch them. Retaining data across power loss and decoding the command bus are left to the surrounding logic.

Top module: `otp_prot_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `busy`, `done` and `err` are 0.
- R2: A cycle with `fact_init` high sets all user words (85h–88h) to FFFFh and both lock bits to 1, so the lock word at 80h reads FFFEh and `sec_blk_protect` is 0. It also cancels any operation in flight: no `done` pulse follows, and the block is idle on the next cycle.
- R3: Word 81h+k (k = 0..3) reads `UID_VAL[16k+15:16k]`.
- R4: A request is taken when `prog_req` is high and `busy` is low. `busy` is then high for exactly `BUSY_CYC` cycles. In the cycle after the last of these, `done` is high for one cycle and `err` is valid in that same cycle. Requests made while `busy` is high are ignored.
- R5: Programming a user word 85h–88h while lock bit 1 is still 1 stores old AND data, with `err` = 0. A 1 in the data never sets a bit that is already cleared.
- R6: Programming the identifier words 81h–84h, or any address outside 80h–88h, fails with `err` = 1 and changes nothing.
- R7: The lock word reads as {13 ones, bit2, bit1, 0}. A program to 80h whose data has a 0 in bit 0 or in any of bits 15:3 fails with `err` = 1 and changes nothing. Otherwise lock bits 1 and 2 are ANDed with data bits 1 and 2.
- R8: Once lock bit 1 is 0, every program to 80h or to 85h–88h fails with `err` = 1 and leaves the stored words unchanged.
- R9: Once lock bit 2 is 0, `sec_blk_protect` is 1 and stays 1 until the next `fact_init`.
- R10: `rd_hit` is 1 for `rd_addr` 80h–88h. For any other address, `rd_hit` is 0 and `rd_data` is 0000h.
- R11: Stored words change only on the edge that raises `done`. A read of the target word shows the new value during the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencing state |
| fact_init | input | 1 | Factory initialisation: erases the user words and lock bits, and cancels any operation |
| prog_req | input | 1 | Program request |
| prog_addr | input | 8 | Word address of the program request |
| prog_data | input | 16 | Data of the program request (a 0 clears the bit) |
| busy | output | 1 | Program operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid while `done` is high |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 16 | Read word, combinational |
| rd_hit | output | 1 | `rd_addr` lies within 80h–88h |
| sec_blk_protect | output | 1 | Security block (parameter block 0) is permanently protected |

## Verification
Two pairs of events can fall in the same cycle. First, the cycle in which `done` pulses is also the first cycle in which a new request can be taken. The bench holds `prog_req` high through a whole operation with a second target already on the bus. It then checks that the second operation starts exactly on the done cycle, and that the read port already shows the first committed word in that cycle. Second, `fact_init` can arrive while an operation is busy. The bench raises it mid-operation and checks that no done pulse appears and that the target word stays erased. A behavioural reference model runs alongside the block and judges every output on every cycle, including long runs of mixed requests in which the lock progressively closes.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int WORD_W    = 16;
  localparam int ADR_W     = 8;
  localparam int SEG_WORDS = 4;
  localparam int IDX_W     = $clog2(SEG_WORDS);
  localparam int UID_W     = SEG_WORDS * WORD_W;
  localparam int SEG_FLAT  = SEG_WORDS * WORD_W;

  localparam logic [ADR_W-1:0] LOCK_ADR = 8'h80;
  // offsets from LOCK_ADR: identifier words then user words
  localparam logic [ADR_W-1:0] UID_OFF  = 8'd1;
  localparam logic [ADR_W-1:0] OTP_OFF  = UID_OFF + ADR_W'(SEG_WORDS);
  localparam logic [ADR_W-1:0] END_OFF  = OTP_OFF + ADR_W'(SEG_WORDS);

  // lock bits the user may clear: bit 1 (segment) and bit 2 (security block)
  localparam logic [WORD_W-1:0] LOCK_USER_MASK = 16'h0006;

  typedef enum logic [1:0] {
    RG_NONE,
    RG_LOCK,
    RG_UID,
    RG_OTP
  } region_e;

  typedef struct packed {
    region_e          rg;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic dec_t decode(input logic [ADR_W-1:0] a);
    dec_t             d;
    logic [ADR_W-1:0] off;
    off   = a - LOCK_ADR;
    d.rg  = RG_NONE;
    d.idx = '0;
    if (off == '0) begin
      d.rg = RG_LOCK;
    end else if (off < OTP_OFF) begin
      d.rg  = RG_UID;
      d.idx = IDX_W'(off - UID_OFF);
    end else if (off < END_OFF) begin
      d.rg  = RG_OTP;
      d.idx = IDX_W'(off - OTP_OFF);
    end
    return d;
  endfunction

endpackage

// File: rtl/otp_policy.sv
module otp_policy
  import otp_pkg::*;
(
  input  logic [ADR_W-1:0]  addr,
  input  logic [WORD_W-1:0] data,
  input  logic              lk_seg,
  output dec_t              dec,
  output logic              reject
);

  always_comb begin
    dec = decode(addr);
    unique case (dec.rg)
      // lock word: frozen by the segment bit, only bits 1 and 2 clearable
      RG_LOCK: reject = !lk_seg || ((data | LOCK_USER_MASK) != '1);
      RG_OTP:  reject = !lk_seg;
      default: reject = 1'b1;
    endcase
  end

endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fact_init,
  input  logic              prog_req,
  input  logic [ADR_W-1:0]  prog_addr,
  input  logic [WORD_W-1:0] prog_data,
  input  logic              reject,
  output logic              busy,
  output logic              fire,
  output logic [ADR_W-1:0]  cap_addr,
  output logic [WORD_W-1:0] cap_data,
  output logic              done,
  output logic              err
);

  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             take;

  always_comb begin
    fire   = busy_q && (cnt_q == '0) && !fact_init;
    take   = !busy_q && prog_req && !fact_init;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (fact_init) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (fire) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      err_d  = reject;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end else if (take) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // request capture, clock-enabled on acceptance only
  always_ff @(posedge clk) begin
    if (take) begin
      cap_addr <= prog_addr;
      cap_data <= prog_data;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r4_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fire && !fact_init) |=> busy_q);

  a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q));

  a_r2_init_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    fact_init |=> (!busy_q && !done_q));

endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fact_init,
  input  logic                we,
  input  dec_t                dec,
  input  logic [WORD_W-1:0]   data,
  output logic                lk_seg,
  output logic                lk_sec,
  output logic [SEG_FLAT-1:0] seg_flat
);

  logic lk_seg_d, lk_sec_d, lk_en;

  always_comb begin
    lk_en    = fact_init || (we && dec.rg == RG_LOCK);
    lk_seg_d = lk_seg;
    lk_sec_d = lk_sec;
    if (fact_init) begin
      lk_seg_d = 1'b1;
      lk_sec_d = 1'b1;
    end else if (we && dec.rg == RG_LOCK) begin
      lk_seg_d = lk_seg & data[1];
      lk_sec_d = lk_sec & data[2];
    end
  end

  always_ff @(posedge clk) begin
    if (lk_en) begin
      lk_seg <= lk_seg_d;
      lk_sec <= lk_sec_d;
    end
  end

  for (genvar i = 0; i < SEG_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] w_q, w_d;
    logic              w_hit, w_en;

    always_comb begin
      w_hit = we && (dec.rg == RG_OTP) && (dec.idx == IDX_W'(i));
      w_en  = fact_init || w_hit;
      w_d   = fact_init ? '1 : (w_q & data);
    end

    always_ff @(posedge clk) begin
      if (w_en) w_q <= w_d;
    end

    assign seg_flat[i*WORD_W +: WORD_W] = w_q;
  end

  a_r5_no_bit_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !fact_init |=> ((seg_flat & ~$past(seg_flat)) == '0));

  a_r8_segment_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_seg && !fact_init) |=> ($stable(seg_flat) && $stable(lk_sec) && !lk_seg));

  a_r11_change_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !fact_init) |=> ($stable(seg_flat) && $stable(lk_seg) && $stable(lk_sec)));

endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl
  import otp_pkg::*;
#(
  parameter int               BUSY_CYC = 8,
  parameter logic [UID_W-1:0] UID_VAL  = 64'h5A3C_96E1_0F7B_D248
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fact_init,
  input  logic              prog_req,
  input  logic [ADR_W-1:0]  prog_addr,
  input  logic [WORD_W-1:0] prog_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [ADR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              sec_blk_protect
);

  logic                fire, reject, lk_seg, lk_sec;
  logic [ADR_W-1:0]    cap_addr;
  logic [WORD_W-1:0]   cap_data;
  logic [SEG_FLAT-1:0] seg_flat;
  dec_t                wdec, rdec;

  otp_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fact_init (fact_init),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .reject    (reject),
    .busy      (busy),
    .fire      (fire),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data),
    .done      (done),
    .err       (err)
  );

  otp_policy u_policy (
    .addr   (cap_addr),
    .data   (cap_data),
    .lk_seg (lk_seg),
    .dec    (wdec),
    .reject (reject)
  );

  otp_array u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .fact_init (fact_init),
    .we        (fire && !reject),
    .dec       (wdec),
    .data      (cap_data),
    .lk_seg    (lk_seg),
    .lk_sec    (lk_sec),
    .seg_flat  (seg_flat)
  );

  always_comb begin
    rdec   = decode(rd_addr);
    rd_hit = (rdec.rg != RG_NONE);
    unique case (rdec.rg)
      RG_LOCK: rd_data = {{(WORD_W-3){1'b1}}, lk_sec, lk_seg, 1'b0};
      RG_UID:  rd_data = UID_VAL[rdec.idx*WORD_W +: WORD_W];
      RG_OTP:  rd_data = seg_flat[rdec.idx*WORD_W +: WORD_W];
      default: rd_data = '0;
    endcase
  end

  assign sec_blk_protect = !lk_sec;

  a_r9_sec_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_blk_protect && !fact_init) |=> sec_blk_protect);

  a_r6_bad_target_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (wdec.rg == RG_UID || wdec.rg == RG_NONE)) |=> (done && err));

endmodule

// File: tb/tb_otp_prot_ctrl.sv
`timescale 1ns/1ps
module tb_otp_prot_ctrl;

  localparam int          BC   = 5;
  localparam logic [63:0] UIDV = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst_n, fact_init, prog_req;
  logic [7:0]  prog_addr, rd_addr;
  logic [15:0] prog_data, rd_data;
  logic        busy, done, err, rd_hit, sec_blk_protect;

  always #2.5 clk = ~clk;

  otp_prot_ctrl #(.BUSY_CYC(BC), .UID_VAL(UIDV)) dut (
    .clk(clk), .rst_n(rst_n), .fact_init(fact_init), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy), .done(done),
    .err(err), .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit),
    .sec_blk_protect(sec_blk_protect)
  );

  int    compared = 0, mismatched = 0;
  bit    finished = 0;
  string cur = "R1";

  // reference model state
  logic        m_busy, m_done, m_err, m_lk1, m_lk2;
  int          m_cnt;
  logic [7:0]  m_a;
  logic [15:0] m_d;
  logic [15:0] m_otp [4];
  bit          known = 0;

  function automatic bit m_reject(logic [7:0] a, logic [15:0] d);
    if (a == 8'h80) return !m_lk1 || d[0] == 1'b0 || d[15:3] != 13'h1FFF;
    if (a >= 8'h85 && a <= 8'h88) return !m_lk1;
    return 1'b1;
  endfunction

  function automatic logic [15:0] m_read(logic [7:0] a);
    if (a == 8'h80) return {13'h1FFF, m_lk2, m_lk1, 1'b0};
    if (a >= 8'h81 && a <= 8'h84) return UIDV[(int'(a) - 'h81) * 16 +: 16];
    if (a >= 8'h85 && a <= 8'h88) return m_otp[int'(a) - 'h85];
    return 16'h0000;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
    end else if (fact_init) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
      m_lk1 = 1; m_lk2 = 1;
      foreach (m_otp[i]) m_otp[i] = 16'hFFFF;
      known = 1;
    end else begin
      m_done = 0; m_err = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_err = m_reject(m_a, m_d);
          if (!m_err) begin
            if (m_a == 8'h80) begin
              m_lk1 = m_lk1 & m_d[1];
              m_lk2 = m_lk2 & m_d[2];
            end else begin
              m_otp[int'(m_a) - 'h85] = m_otp[int'(m_a) - 'h85] & m_d;
            end
          end
        end else begin
          m_cnt--;
        end
      end else if (prog_req) begin
        m_busy = 1; m_cnt = BC - 1; m_a = prog_addr; m_d = prog_data;
      end
    end
  endtask

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(cur, "busy", 32'(busy), 32'(m_busy));
    chk(cur, "done", 32'(done), 32'(m_done));
    chk(cur, "err",  32'(err),  32'(m_err));
    if (known) begin
      chk(cur, "rd_data", 32'(rd_data), 32'(m_read(rd_addr)));
      chk(cur, "rd_hit", 32'(rd_hit), 32'(rd_addr >= 8'h80 && rd_addr <= 8'h88));
      chk(cur, "sec_blk_protect", 32'(sec_blk_protect), 32'(!m_lk2));
    end
  endtask

  task automatic rd_now(string req, logic [7:0] a, logic [15:0] exp);
    rd_addr = a;
    #0.5;
    chk(req, $sformatf("word %h", a), 32'(rd_data), 32'(exp));
  endtask

  task automatic init_step();
    fact_init = 1; step(); fact_init = 0;
  endtask

  // issue one program and return at the negedge where done is visible
  task automatic prog(logic [7:0] a, logic [15:0] d);
    prog_req = 1; prog_addr = a; prog_data = d;
    step();
    // ignored traffic while busy, withdrawn before the completion edge
    prog_addr = 8'h85; prog_data = 16'h0000;
    while (m_busy) begin
      prog_req = (m_cnt > 0);
      step();
    end
    prog_req = 0;
  endtask

  initial begin
    rst_n = 0; fact_init = 0; prog_req = 0;
    prog_addr = 8'h00; prog_data = 16'hFFFF; rd_addr = 8'h80;
    m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
    m_lk1 = 1; m_lk2 = 1; m_a = 0; m_d = 0;
    foreach (m_otp[i]) m_otp[i] = 16'hFFFF;

    cur = "R1";
    step(); step();
    chk("R1", "busy in reset", 32'(busy), 0);
    chk("R1", "done in reset", 32'(done), 0);
    rst_n = 1;
    step();
    chk("R1", "err after reset", 32'(err), 0);

    cur = "R2";
    init_step();
    rd_now("R2", 8'h80, 16'hFFFE);
    rd_now("R2", 8'h87, 16'hFFFF);
    chk("R2", "sec_blk_protect", 32'(sec_blk_protect), 0);

    cur = "R3";
    rd_now("R3", 8'h81, 16'hCDEF);
    rd_now("R3", 8'h82, 16'h89AB);
    rd_now("R3", 8'h83, 16'h4567);
    rd_now("R3", 8'h84, 16'h0123);

    cur = "R10";
    rd_now("R10", 8'h7F, 16'h0000);
    chk("R10", "hit 7F", 32'(rd_hit), 0);
    rd_now("R10", 8'h89, 16'h0000);
    chk("R10", "hit 89", 32'(rd_hit), 0);
    rd_now("R10", 8'h88, 16'hFFFF);
    chk("R10", "hit 88", 32'(rd_hit), 1);

    cur = "R4";
    begin
      int nb = 0;
      prog_req = 1; prog_addr = 8'h85; prog_data = 16'hF0F0;
      step();
      prog_addr = 8'h86; prog_data = 16'h0000;
      while (busy) begin
        nb++;
        prog_req = (m_cnt > 0);
        step();
      end
      prog_req = 0;
      chk("R4", "busy length", 32'(nb), 32'(BC));
      chk("R4", "done at end", 32'(done), 1);
      step();
      chk("R4", "done single", 32'(done), 0);
      rd_now("R4", 8'h86, 16'hFFFF);
    end

    cur = "R5";
    rd_now("R5", 8'h85, 16'hF0F0);
    prog(8'h85, 16'h0FFF);
    chk("R5", "err", 32'(err), 0);
    rd_now("R5", 8'h85, 16'h00F0);
    prog(8'h85, 16'hFFFF);
    rd_now("R5", 8'h85, 16'h00F0);

    cur = "R6";
    prog(8'h82, 16'h0000);
    chk("R6", "err uid", 32'(err), 1);
    rd_now("R6", 8'h82, 16'h89AB);
    prog(8'h90, 16'h0000);
    chk("R6", "err out of range", 32'(err), 1);

    cur = "R7";
    prog(8'h80, 16'hFFFE);
    chk("R7", "err bit0", 32'(err), 1);
    prog(8'h80, 16'h7FF9);
    chk("R7", "err bit15", 32'(err), 1);
    rd_now("R7", 8'h80, 16'hFFFE);

    cur = "R9";
    prog(8'h80, 16'hFFFB);
    chk("R9", "err", 32'(err), 0);
    chk("R9", "sec_blk_protect", 32'(sec_blk_protect), 1);
    rd_now("R9", 8'h80, 16'hFFFA);
    prog(8'h80, 16'hFFFF);
    chk("R9", "sec stays", 32'(sec_blk_protect), 1);

    cur = "R11";
    prog_req = 1; prog_addr = 8'h86; prog_data = 16'h1234;
    step();
    prog_addr = 8'h87; prog_data = 16'h5678;
    while (m_busy) step();
    rd_addr = 8'h86;
    #0.5;
    chk("R11", "done", 32'(done), 1);
    chk("R11", "word 86 in done cycle", 32'(rd_data), 32'h1234);
    step();
    prog_req = 0;
    chk("R11", "second op taken in done cycle", 32'(busy), 1);
    while (m_busy) step();
    rd_now("R11", 8'h87, 16'h5678);
    step();

    cur = "R8";
    prog(8'h80, 16'hFFFD);
    chk("R8", "lock err", 32'(err), 0);
    prog(8'h88, 16'h0000);
    chk("R8", "otp err", 32'(err), 1);
    rd_now("R8", 8'h88, 16'hFFFF);
    prog(8'h80, 16'hFFFF);
    chk("R8", "lock word err", 32'(err), 1);
    rd_now("R8", 8'h80, 16'hFFF8);

    cur = "R2";
    init_step();
    rd_now("R2", 8'h80, 16'hFFFE);
    prog_req = 1; prog_addr = 8'h85; prog_data = 16'h0000;
    step(); prog_req = 0;
    step();
    init_step();
    for (int k = 0; k < BC + 2; k++) begin
      step();
      chk("R2", "no done after cancel", 32'(done), 0);
    end
    rd_now("R2", 8'h85, 16'hFFFF);

    cur = "R5";
    for (int n = 0; n < 250; n++) begin
      logic [7:0]  a;
      logic [15:0] d;
      a = 8'h7F + 8'($urandom_range(0, 10));
      d = 16'($urandom) | 16'($urandom);
      if (a == 8'h80 && $urandom_range(0, 1) == 1) d = d | 16'hFFF9;
      rd_addr = 8'h7F + 8'($urandom_range(0, 10));
      if ($urandom_range(0, 24) == 0) init_step();
      prog(a, d);
      step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule